// File: doc/BRIEF.md
# I2C Peripheral Control Register

This block holds the six control bits of a two-wire (I2C) master/slave peripheral. It sits between a simple CPU write/read port and the protocol engine that drives the bus. Software writes a byte to set the control bits and reads the same byte back. The engine receives the control levels it needs: enable, general-call acceptance, start request, acknowledge enable, and a stop/release request whose meaning depends on the current mode. The engine reports bus events as one-cycle pulses: start condition sent, stop condition sent, and byte transfer finished.

The register also applies the hardware rules that make software writes incomplete on their own. Disabling the peripheral clears most of the bits. The start request clears itself once the start goes out. In master mode the stop request clears itself once the stop goes out. In slave mode, only software can clear the stop request. While the peripheral is disabled, the first write that enables it stores nothing but the enable bit. The block also combines event pulses into an interrupt, and pending-service flags into a request to hold SCL low.

Top module: `i2c_ctl_reg`

## Requirements
- R1: After reset the read value is 00h. Bits 7:6 always read 0, whatever is written.
- R2: The read layout is bit 5 enable, bit 4 general-call enable, bit 3 start request, bit 2 acknowledge enable, bit 1 stop request, bit 0 interrupt enable. A write while enable is 0 whose bit 5 is 1 sets only the enable bit. All other bits keep their values.
- R3: A write made while enable is 1 stores bits 5:0 as written.
- R4: While enable is 0, the general-call, start, acknowledge and interrupt-enable bits are held at 0. The stop bit keeps its value. `bus_release` is 1 and the stop/release outputs are 0.
- R5: A start-sent pulse clears the start bit. If a write sets that bit in the same cycle, the clear wins.
- R6: In master mode (`is_master`=1), `master_stop_req` follows the stop bit, and a stop-sent pulse clears the stop bit.
- R7: In slave mode, `slave_release_req` follows the stop bit. Stop-sent and byte-done pulses leave the stop bit unchanged.
- R8: `irq` is 1 exactly when interrupt enable is 1 and at least one event pulse (start-sent, stop-sent, byte-done) is present.
- R9: `scl_hold` is 1 when enable is 1 and any bit of `hold_flags` is set. It is 0 while enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | CPU write strobe |
| wr_data | input | 8 | CPU write byte |
| rd_data | output | 8 | Register read value |
| is_master | input | 1 | Engine mode: 1 master, 0 slave |
| ev_start_sent | input | 1 | Pulse: start condition sent |
| ev_stop_sent | input | 1 | Pulse: stop condition sent |
| ev_byte_done | input | 1 | Pulse: byte transfer finished |
| hold_flags | input | FLAG_W | Pending-service flags from the engine |
| ctl_enable | output | 1 | Enable level to the engine |
| gcall_en | output | 1 | Accept the general-call address (receive only) |
| start_req | output | 1 | Start condition request |
| ack_en | output | 1 | Acknowledge received bytes |
| master_stop_req | output | 1 | Master: send stop after current byte or start |
| slave_release_req | output | 1 | Slave: release SCL/SDA after current byte |
| bus_release | output | 1 | Release all bus outputs (disabled) |
| irq | output | 1 | Interrupt request |
| scl_hold | output | 1 | Request to hold SCL low |

## Verification
The bench first writes the register with enable clear, then with enable set, and compares the read-back values. This separates the first-write rule from a normal write. Each event pulse is then driven in both modes. This shows whether the stop-sent clear is tied to master mode only, and whether the start clear beats a simultaneous write. A disable write that also sets the acknowledge and stop bits shows which bits survive disabling. The output levels are compared before each clock edge, with interrupt enable on and off and with flags on and off, to separate the event and enable gating of `irq` and `scl_hold`.

// File: rtl/i2c_ctl_pkg.sv
package i2c_ctl_pkg;
  localparam int DATA_W   = 8;
  localparam int BIT_PE   = 5;
  localparam int BIT_GC   = 4;
  localparam int BIT_STA  = 3;
  localparam int BIT_ACK  = 2;
  localparam int BIT_STO  = 1;
  localparam int BIT_ITE  = 0;
  localparam int CTL_BITS = 6;

  typedef struct packed {
    logic pe;
    logic gc;
    logic start;
    logic ack;
    logic stop;
    logic ite;
  } ctl_bits_t;
endpackage

// File: rtl/i2c_ctl_next.sv
module i2c_ctl_next
  import i2c_ctl_pkg::*;
(
  input  ctl_bits_t         cur,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              is_master,
  input  logic              ev_start_sent,
  input  logic              ev_stop_sent,
  output ctl_bits_t         nxt
);
  logic unused_rsvd;
  assign unused_rsvd = ^wr_data[DATA_W-1:CTL_BITS];

  always_comb begin
    nxt = cur;
    if (wr_en) begin
      if (!cur.pe) begin
        // disabled: enabling write stores only the enable bit
        if (wr_data[BIT_PE]) nxt.pe   = 1'b1;
        else                 nxt.stop = wr_data[BIT_STO];
      end else begin
        nxt.pe    = wr_data[BIT_PE];
        nxt.gc    = wr_data[BIT_GC];
        nxt.start = wr_data[BIT_STA];
        nxt.ack   = wr_data[BIT_ACK];
        nxt.stop  = wr_data[BIT_STO];
        nxt.ite   = wr_data[BIT_ITE];
      end
    end
    // hardware clears override software writes
    if (ev_start_sent)             nxt.start = 1'b0;
    if (is_master && ev_stop_sent) nxt.stop  = 1'b0;
    if (!nxt.pe) begin
      nxt.gc    = 1'b0;
      nxt.start = 1'b0;
      nxt.ack   = 1'b0;
      nxt.ite   = 1'b0;
    end
  end
endmodule

// File: rtl/i2c_ctl_drive.sv
module i2c_ctl_drive
  import i2c_ctl_pkg::*;
#(
  parameter int FLAG_W = 4
) (
  input  ctl_bits_t         q,
  input  logic              is_master,
  input  logic              ev_start_sent,
  input  logic              ev_stop_sent,
  input  logic              ev_byte_done,
  input  logic [FLAG_W-1:0] hold_flags,
  output logic [DATA_W-1:0] rd_data,
  output logic              master_stop_req,
  output logic              slave_release_req,
  output logic              bus_release,
  output logic              irq,
  output logic              scl_hold
);
  localparam int RSVD_W = DATA_W - CTL_BITS;

  logic any_event;

  always_comb begin
    rd_data           = {{RSVD_W{1'b0}}, q};
    any_event         = ev_start_sent | ev_stop_sent | ev_byte_done;
    bus_release       = ~q.pe;
    master_stop_req   = q.pe & q.stop & is_master;
    slave_release_req = q.pe & q.stop & ~is_master;
    irq               = q.ite & any_event;
    scl_hold          = q.pe & (|hold_flags);
  end
endmodule

// File: rtl/i2c_ctl_reg.sv
module i2c_ctl_reg
  import i2c_ctl_pkg::*;
#(
  parameter int FLAG_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data,
  input  logic              is_master,
  input  logic              ev_start_sent,
  input  logic              ev_stop_sent,
  input  logic              ev_byte_done,
  input  logic [FLAG_W-1:0] hold_flags,
  output logic              ctl_enable,
  output logic              gcall_en,
  output logic              start_req,
  output logic              ack_en,
  output logic              master_stop_req,
  output logic              slave_release_req,
  output logic              bus_release,
  output logic              irq,
  output logic              scl_hold
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  ctl_bits_t  ctl_q;
  ctl_bits_t  ctl_d;
  logic       ctl_ce;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  i2c_ctl_next u_next (
    .cur           (ctl_q),
    .wr_en         (wr_en),
    .wr_data       (wr_data),
    .is_master     (is_master),
    .ev_start_sent (ev_start_sent),
    .ev_stop_sent  (ev_stop_sent),
    .nxt           (ctl_d)
  );

  assign ctl_ce = wr_en | ev_start_sent | ev_stop_sent;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  ctl_q <= '0;
    else if (ctl_ce) ctl_q <= ctl_d;
  end

  i2c_ctl_drive #(.FLAG_W(FLAG_W)) u_drive (
    .q                 (ctl_q),
    .is_master         (is_master),
    .ev_start_sent     (ev_start_sent),
    .ev_stop_sent      (ev_stop_sent),
    .ev_byte_done      (ev_byte_done),
    .hold_flags        (hold_flags),
    .rd_data           (rd_data),
    .master_stop_req   (master_stop_req),
    .slave_release_req (slave_release_req),
    .bus_release       (bus_release),
    .irq               (irq),
    .scl_hold          (scl_hold)
  );

  assign ctl_enable = ctl_q.pe;
  assign gcall_en   = ctl_q.gc;
  assign start_req  = ctl_q.start;
  assign ack_en     = ctl_q.ack;

  AST_FIRST_WRITE_PE_ONLY: assert property (@(posedge clk) disable iff (!rst_int_n)
    (wr_en && !ctl_q.pe && wr_data[BIT_PE]) |=> (ctl_q.pe && rd_data[4:0] == $past(rd_data[4:0]))); // R2
  AST_DISABLED_CLEARS: assert property (@(posedge clk) disable iff (!rst_int_n)
    !ctl_q.pe |-> (!ctl_q.gc && !ctl_q.start && !ctl_q.ack && !ctl_q.ite && bus_release)); // R4
  AST_START_SENT_CLEARS: assert property (@(posedge clk) disable iff (!rst_int_n)
    ev_start_sent |=> !start_req); // R5
  AST_MASTER_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_int_n)
    (is_master && ev_stop_sent) |=> !ctl_q.stop); // R6
  AST_SLAVE_STOP_KEPT: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!is_master && !wr_en && ctl_q.stop) |=> ctl_q.stop); // R7
  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_int_n)
    irq |-> (ctl_q.ite && (ev_start_sent || ev_stop_sent || ev_byte_done))); // R8
  AST_HOLD_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_int_n)
    scl_hold |-> ctl_enable); // R9
endmodule

// File: tb/i2c_ctl_reg_test.sv
module i2c_ctl_reg_test;
  localparam int FLAG_W = 4;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              wr_en;
  logic [7:0]        wr_data;
  logic [7:0]        rd_data;
  logic              is_master;
  logic              ev_start_sent, ev_stop_sent, ev_byte_done;
  logic [FLAG_W-1:0] hold_flags;
  logic ctl_enable, gcall_en, start_req, ack_en;
  logic master_stop_req, slave_release_req, bus_release, irq, scl_hold;

  always #5 clk = ~clk;

  i2c_ctl_reg #(.FLAG_W(FLAG_W)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .is_master(is_master), .ev_start_sent(ev_start_sent), .ev_stop_sent(ev_stop_sent),
    .ev_byte_done(ev_byte_done), .hold_flags(hold_flags), .ctl_enable(ctl_enable),
    .gcall_en(gcall_en), .start_req(start_req), .ack_en(ack_en),
    .master_stop_req(master_stop_req), .slave_release_req(slave_release_req),
    .bus_release(bus_release), .irq(irq), .scl_hold(scl_hold)
  );

  // output levels: {bus_release, master_stop_req, slave_release_req, irq, scl_hold}
  logic [7:0] obs;
  assign obs = {3'b000, bus_release, master_stop_req, slave_release_req, irq, scl_hold};

  typedef struct {
    string      tag;
    bit         is_rd;
    logic [7:0] exp;
  } item_t;

  item_t sb_q[$];
  event  mon_ev;
  int    errors = 0;
  int    checks = 0;
  bit    done = 1'b0;

  // monitor: pops expected items and compares with the design
  initial begin
    forever begin
      @(mon_ev);
      while (sb_q.size() > 0) begin
        item_t it;
        logic [7:0] act;
        it  = sb_q.pop_front();
        act = it.is_rd ? rd_data : obs;
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s %s actual=%02h expected=%02h", it.tag,
                   it.is_rd ? "rd_data" : "levels", act, it.exp);
        end
      end
    end
  end

  task automatic push(input string tag, input bit is_rd, input logic [7:0] exp);
    item_t it;
    it.tag = tag; it.is_rd = is_rd; it.exp = exp;
    sb_q.push_back(it);
    ->mon_ev;
    #1;
  endtask

  // ev = {byte_done, stop_sent, start_sent}
  task automatic step(input bit w, input logic [7:0] d, input logic [2:0] ev, input bit m,
                      input logic [FLAG_W-1:0] fl, input int lvl_exp, input int rd_exp,
                      input string tag);
    @(negedge clk);
    wr_en = w; wr_data = d; is_master = m; hold_flags = fl;
    {ev_byte_done, ev_stop_sent, ev_start_sent} = ev;
    #1;
    if (lvl_exp >= 0) push(tag, 1'b0, lvl_exp[7:0]);
    @(posedge clk);
    #1;
    wr_en = 1'b0;
    {ev_byte_done, ev_stop_sent, ev_start_sent} = 3'b000;
    if (rd_exp >= 0) push(tag, 1'b1, rd_exp[7:0]);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; is_master = 1'b1;
    ev_start_sent = 1'b0; ev_stop_sent = 1'b0; ev_byte_done = 1'b0; hold_flags = '0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    step(0, 8'h00, 3'b000, 1, 4'h0, 8'h10, 8'h00, "R1 reset value, R4 released");
    step(1, 8'h3F, 3'b000, 1, 4'h0, -1,    8'h20, "R2 first write sets only enable");
    step(1, 8'h3D, 3'b000, 1, 4'h0, -1,    8'h3D, "R3 enabled write stores bits");
    step(0, 8'h00, 3'b001, 1, 4'h0, 8'h02, 8'h35, "R5 R8 start-sent clears start, irq");
    step(1, 8'h3F, 3'b001, 1, 4'h0, -1,    8'h37, "R5 clear wins over write");
    step(0, 8'h00, 3'b000, 1, 4'h0, 8'h08, 8'h37, "R6 master stop level");
    step(0, 8'h00, 3'b010, 1, 4'h0, 8'h0A, 8'h35, "R6 stop-sent clears in master");
    step(1, 8'h37, 3'b000, 0, 4'h0, -1,    8'h37, "R3 set stop in slave");
    step(0, 8'h00, 3'b010, 0, 4'h0, 8'h06, 8'h37, "R7 stop kept in slave");
    step(0, 8'h00, 3'b100, 0, 4'h2, 8'h07, 8'h37, "R7 R9 byte-done, hold request");
    step(1, 8'h32, 3'b000, 0, 4'h0, -1,    8'h32, "R3 interrupt enable off");
    step(0, 8'h00, 3'b100, 0, 4'h0, 8'h04, 8'h32, "R8 no irq when disabled");
    step(1, 8'h06, 3'b000, 0, 4'h0, -1,    8'h02, "R4 disable keeps only stop");
    step(0, 8'h00, 3'b000, 0, 4'hF, 8'h10, 8'h02, "R4 R9 outputs released");
    step(1, 8'h3F, 3'b000, 0, 4'h0, -1,    8'h22, "R2 first write keeps stop");
    step(1, 8'hFF, 3'b000, 1, 4'h0, -1,    8'h3F, "R1 reserved bits read 0");
    step(0, 8'h00, 3'b001, 1, 4'h0, 8'h0A, 8'h37, "R5 R6 start-sent with stop pending");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule